// File: doc/BRIEF.md
# Warp Memory Access Coalescing Checker

This block looks at the global-memory requests that one warp of lanes issues together. It decides whether they can be served as one wide memory transaction. Each lane presents a byte address and an active bit. The whole warp shares one access-size code. The request is merged only when three conditions hold together. Every active lane must be aligned to the access size. The active lanes must cover one unbroken byte range. Rising lane index must map to rising address.

For a mergeable request, the block returns the start address and the byte length of the single transaction. Otherwise it reports how many separate transactions the request needs, which is one for each active lane. The result is registered. A response appears one clock after the request strobe, so a new request can be accepted every cycle. Issuing the transactions and moving the data are left to the logic downstream.

Top module: `warp_coalesce_check`

## Requirements
- R1: A response strobe `rspValid` is high in exactly the cycle after each cycle in which `reqValid` was sampled high, and low otherwise. Requests may arrive in back-to-back cycles.
- R2: `accSize` encodes the per-lane size as 0 = 4 bytes, 1 = 8 bytes and 2 = 16 bytes. Code 3 is reserved, and any request that carries it is reported as not mergeable.
- R3: If any active lane's address is not a multiple of the access size, the request is not mergeable. This includes the case where the lowest active lane is misaligned.
- R4: Each active lane must sit at the lowest active lane's address plus its rank times the size. Its rank is the number of active lanes with a smaller index. A skipped slot makes the request not mergeable.
- R5: If two active lanes carry each other's addresses, the request is not mergeable, even though the set of addresses is still contiguous.
- R6: Inactive lanes play no part in the decision. Their addresses may hold any value, and gaps in the lane index between active lanes are allowed.
- R7: A mergeable response sets `coalesced` = 1, `txnCount` = 1, `txnBase` = the lowest active lane's address, and `txnLen` = active-lane count times size.
- R8: A non-mergeable response that has at least one active lane sets `coalesced` = 0, `txnCount` = active-lane count, and `txnBase` = `txnLen` = 0.
- R9: A request with no active lane gives `coalesced` = 0, `txnCount` = 0, `txnBase` = 0 and `txnLen` = 0.
- R10: While `rst_n` is low, `rspValid`, `coalesced`, `txnBase`, `txnLen` and `txnCount` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A warp request is presented this cycle |
| laneValid | input | LANES | Active bit for each lane |
| laneAddr | input | LANES*ADDR_W | Byte address for each lane; lane i occupies bits [i*ADDR_W +: ADDR_W] |
| accSize | input | 2 | Shared access-size code (see R2) |
| rspValid | output | 1 | The result fields are valid |
| coalesced | output | 1 | The request merges into one transaction |
| txnBase | output | ADDR_W | Start address of the merged transaction |
| txnLen | output | $clog2(LANES*16+1) | Byte length of the merged transaction |
| txnCount | output | $clog2(LANES+1) | Number of transactions needed |

## Verification
Two cases are hard to reach. The first is a warp whose addresses form a perfect contiguous set but sit in the wrong lanes. The second is a warp where every lane is consistent with the lowest one, yet that lowest lane is misaligned. Random addresses almost never produce either case. The bench therefore builds each warp from a base, a mask and a size, and places every active lane at its ideal address. It then applies exactly one deliberate defect: swapping two lanes, nudging one lane off alignment, opening a one-slot hole, or starting from a misaligned base. Inactive lanes are filled with misaligned junk, which shows that they are ignored.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

  // Shared access-size encoding.
  typedef enum logic [1:0] {
    SIZE_4B  = 2'd0,
    SIZE_8B  = 2'd1,
    SIZE_16B = 2'd2,
    SIZE_RSV = 2'd3
  } size_code_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;      // capture a new result
    logic markMerge; // the captured result is a single transaction
  } wcc_strobe_t;

  // log2 of the access size in bytes; the reserved code maps to 16 bytes.
  function automatic logic [2:0] sizeShift(input logic [1:0] code);
    case (code)
      SIZE_4B: sizeShift = 3'd2;
      SIZE_8B: sizeShift = 3'd3;
      default: sizeShift = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wcc_datapath.sv
module wcc_datapath
  import wcc_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int LEN_W = $clog2(LANES * 16 + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  wcc_strobe_t               ctrlStb,
  input  logic [LANES-1:0]          laneValid,
  input  logic [LANES*ADDR_W-1:0]   laneAddr,
  input  logic [1:0]                accSize,
  output logic                      allLanesOk,
  output logic                      anyActive,
  output logic                      sizeLegal,
  output logic                      coalesced,
  output logic [ADDR_W-1:0]         txnBase,
  output logic [LEN_W-1:0]          txnLen,
  output logic [CNT_W-1:0]          txnCount
);

  logic [CNT_W-1:0]  rank [LANES+1];
  logic [ADDR_W-1:0] firstAddr;
  logic [ADDR_W-1:0] alignMask;
  logic [2:0]        shamt;
  logic [LANES-1:0]  laneOk;
  logic [CNT_W-1:0]  activeCnt;

  assign shamt     = sizeShift(accSize);
  assign alignMask = (ADDR_W'(1) << shamt) - ADDR_W'(1);
  assign sizeLegal = (accSize != SIZE_RSV);
  assign anyActive = |laneValid;

  // Running count of active lanes below each lane index.
  assign rank[0] = '0;
  for (genvar g = 0; g < LANES; g++) begin : g_rank
    assign rank[g+1] = rank[g] + CNT_W'(laneValid[g]);
  end
  assign activeCnt = rank[LANES];

  // Address of the lowest-indexed active lane.
  always_comb begin
    firstAddr = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (laneValid[i]) firstAddr = laneAddr[i*ADDR_W +: ADDR_W];
    end
  end

  // Per-lane test: aligned, and placed at base + rank * size.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] myAddr;
    logic [ADDR_W-1:0] wantAddr;
    assign myAddr   = laneAddr[g*ADDR_W +: ADDR_W];
    assign wantAddr = firstAddr + (ADDR_W'(rank[g]) << shamt);
    assign laneOk[g] = !laneValid[g] ||
                       (((myAddr & alignMask) == '0) && (myAddr == wantAddr));
  end
  assign allLanesOk = &laneOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coalesced <= 1'b0;
      txnBase   <= '0;
      txnLen    <= '0;
      txnCount  <= '0;
    end else if (ctrlStb.load) begin
      coalesced <= ctrlStb.markMerge;
      if (ctrlStb.markMerge) begin
        txnBase  <= firstAddr;
        txnLen   <= LEN_W'(activeCnt) << shamt;
        txnCount <= CNT_W'(1);
      end else begin
        txnBase  <= '0;
        txnLen   <= '0;
        txnCount <= activeCnt;
      end
    end
  end

endmodule

// File: rtl/wcc_control.sv
module wcc_control
  import wcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        allLanesOk,
  input  logic        anyActive,
  input  logic        sizeLegal,
  output wcc_strobe_t ctrlStb,
  output logic        rspValid
);

  always_comb begin
    ctrlStb.load      = reqValid;
    ctrlStb.markMerge = reqValid && allLanesOk && anyActive && sizeLegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rspValid <= 1'b0;
    else        rspValid <= reqValid;
  end

endmodule

// File: rtl/warp_coalesce_check.sv
module warp_coalesce_check
  import wcc_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int LEN_W = $clog2(LANES * 16 + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [1:0]              accSize,
  output logic                    rspValid,
  output logic                    coalesced,
  output logic [ADDR_W-1:0]       txnBase,
  output logic [LEN_W-1:0]        txnLen,
  output logic [CNT_W-1:0]        txnCount
);

  wcc_strobe_t ctrlStb;
  logic        allLanesOk;
  logic        anyActive;
  logic        sizeLegal;

  wcc_control i_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .allLanesOk (allLanesOk),
    .anyActive  (anyActive),
    .sizeLegal  (sizeLegal),
    .ctrlStb    (ctrlStb),
    .rspValid   (rspValid)
  );

  wcc_datapath #(.LANES(LANES), .ADDR_W(ADDR_W)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlStb    (ctrlStb),
    .laneValid  (laneValid),
    .laneAddr   (laneAddr),
    .accSize    (accSize),
    .allLanesOk (allLanesOk),
    .anyActive  (anyActive),
    .sizeLegal  (sizeLegal),
    .coalesced  (coalesced),
    .txnBase    (txnBase),
    .txnLen     (txnLen),
    .txnCount   (txnCount)
  );

endmodule

// File: rtl/wcc_checker.sv
module wcc_checker
  import wcc_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int LEN_W = $clog2(LANES * 16 + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reqValid,
  input logic [LANES-1:0]        laneValid,
  input logic [1:0]              accSize,
  input logic                    rspValid,
  input logic                    coalesced,
  input logic [ADDR_W-1:0]       txnBase,
  input logic [LEN_W-1:0]        txnLen,
  input logic [CNT_W-1:0]        txnCount
);

  function automatic logic [LEN_W-1:0] expectLen(input logic [LANES-1:0] m,
                                                 input logic [1:0] code);
    expectLen = LEN_W'($countones(m)) << sizeShift(code);
  endfunction

  assert_rsp_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  assert_reserved_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && accSize == SIZE_RSV) |=> !coalesced);

  assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && coalesced) |->
      ((txnBase & ((ADDR_W'(1) << sizeShift($past(accSize))) - ADDR_W'(1))) == '0));

  assert_merge_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && coalesced) |->
      (txnCount == CNT_W'(1) && txnLen == expectLen($past(laneValid), $past(accSize))));

  assert_split_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !coalesced) |->
      (txnCount == CNT_W'($countones($past(laneValid))) && txnBase == '0 && txnLen == '0));

  assert_empty_warp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && laneValid == '0) |=> (!coalesced && txnCount == '0));

endmodule

bind warp_coalesce_check wcc_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .laneValid (laneValid),
  .accSize   (accSize),
  .rspValid  (rspValid),
  .coalesced (coalesced),
  .txnBase   (txnBase),
  .txnLen    (txnLen),
  .txnCount  (txnCount)
);

// File: tb/test_warp_coalesce_check.sv
module test_warp_coalesce_check;

  localparam int LANES  = 16;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int LEN_W  = $clog2(LANES * 16 + 1);

  // Defect kinds applied after ideal placement.
  localparam logic [1:0] K_NONE = 2'd0, K_SWAP = 2'd1, K_NUDGE = 2'd2, K_HOLE = 2'd3;

  typedef struct packed {
    logic [LANES-1:0]  mask;
    logic [1:0]        code;
    logic [ADDR_W-1:0] base;
    logic [1:0]        kind;
    logic [3:0]        laneA;
    logic [3:0]        laneB;
    logic              expOk;
    logic [3:0]        tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 2'd0, 32'h0000_1000, K_NONE,  4'd0, 4'd0, 1'b1, 4'd7}, // R7 4B full warp
    '{16'hFFFF, 2'd1, 32'h0000_2000, K_NONE,  4'd0, 4'd0, 1'b1, 4'd2}, // R2 8B
    '{16'hFFFF, 2'd2, 32'h0000_3000, K_NONE,  4'd0, 4'd0, 1'b1, 4'd2}, // R2 16B
    '{16'h00F0, 2'd0, 32'h0000_0400, K_NONE,  4'd0, 4'd0, 1'b1, 4'd6}, // R6 first lane 4
    '{16'hA5A5, 2'd1, 32'h0000_0800, K_NONE,  4'd0, 4'd0, 1'b1, 4'd6}, // R6 sparse mask
    '{16'hFFFF, 2'd0, 32'h0000_1002, K_NONE,  4'd0, 4'd0, 1'b0, 4'd3}, // R3 misaligned start
    '{16'hFFFF, 2'd2, 32'h0000_3000, K_NUDGE, 4'd5, 4'd0, 1'b0, 4'd3}, // R3 lane 5 off by 4
    '{16'hFFFF, 2'd0, 32'h0000_1000, K_SWAP,  4'd3, 4'd4, 1'b0, 4'd5}, // R5 swap 3/4
    '{16'hFFFF, 2'd1, 32'h0000_2000, K_HOLE,  4'd7, 4'd0, 1'b0, 4'd4}, // R4 hole from lane 7
    '{16'h0001, 2'd2, 32'h0000_1230, K_NONE,  4'd0, 4'd0, 1'b1, 4'd7}, // R7 single lane
    '{16'hFFFF, 2'd3, 32'h0000_0000, K_NONE,  4'd0, 4'd0, 1'b0, 4'd2}, // R2 reserved code
    '{16'h8000, 2'd0, 32'hFFFF_FFFC, K_NONE,  4'd0, 4'd0, 1'b1, 4'd7}, // R7 top lane only
    '{16'hFF00, 2'd1, 32'h0000_0010, K_SWAP,  4'd8, 4'd15, 1'b0, 4'd5} // R5 swap 8/15
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    reqValid = 1'b0;
  logic [LANES-1:0]        laneValid = '0;
  logic [LANES*ADDR_W-1:0] laneAddr = '0;
  logic [1:0]              accSize = '0;
  logic                    rspValid;
  logic                    coalesced;
  logic [ADDR_W-1:0]       txnBase;
  logic [LEN_W-1:0]        txnLen;
  logic [CNT_W-1:0]        txnCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  warp_coalesce_check #(.LANES(LANES), .ADDR_W(ADDR_W)) i_warp_coalesce_check (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .laneValid(laneValid),
    .laneAddr(laneAddr), .accSize(accSize), .rspValid(rspValid),
    .coalesced(coalesced), .txnBase(txnBase), .txnLen(txnLen), .txnCount(txnCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LANES*ADDR_W-1:0] build(input vec_t v);
    logic [ADDR_W-1:0] a [LANES];
    logic [ADDR_W-1:0] t;
    logic [LANES*ADDR_W-1:0] flat;
    int rk = 0;
    int sz = 4 << ((v.code == 2'd3) ? 2 : v.code);
    for (int i = 0; i < LANES; i++) begin
      if (v.mask[i]) begin
        a[i] = v.base + ADDR_W'(rk * sz);
        if (v.kind == K_HOLE && i >= int'(v.laneA)) a[i] = a[i] + ADDR_W'(sz);
        rk++;
      end else begin
        a[i] = 32'hDEAD_BEE1 ^ ADDR_W'(i << 8); // misaligned junk (R6)
      end
    end
    if (v.kind == K_SWAP) begin
      t = a[v.laneA]; a[v.laneA] = a[v.laneB]; a[v.laneB] = t;
    end
    if (v.kind == K_NUDGE) a[v.laneA] = a[v.laneA] + ADDR_W'(4);
    for (int i = 0; i < LANES; i++) flat[i*ADDR_W +: ADDR_W] = a[i];
    return flat;
  endfunction

  task automatic checkResult(input vec_t v, input string req);
    int n = $countones(v.mask);
    int sz = 4 << ((v.code == 2'd3) ? 2 : v.code);
    check(rspValid === 1'b1, "R1", {req, " rspValid"}, rspValid, 1);
    check(coalesced === v.expOk, req, "coalesced", coalesced, v.expOk);
    if (v.expOk) begin
      check(txnBase === v.base, "R7", "txnBase", txnBase, v.base);
      check(txnLen === LEN_W'(n * sz), "R7", "txnLen", txnLen, n * sz);
      check(txnCount === CNT_W'(1), "R7", "txnCount", txnCount, 1);
    end else begin
      check(txnBase === '0, "R8", "txnBase", txnBase, 0);
      check(txnLen === '0, "R8", "txnLen", txnLen, 0);
      check(txnCount === CNT_W'(n), "R8", "txnCount", txnCount, n);
    end
  endtask

  task automatic drive(input vec_t v);
    laneValid = v.mask;
    accSize   = v.code;
    laneAddr  = build(v);
    reqValid  = 1'b1;
  endtask

  initial begin
    vec_t e;
    repeat (3) @(negedge clk);
    // R10: reset state, with a request held at the inputs
    drive(VECS[0]);
    @(negedge clk);
    check(rspValid === 1'b0, "R10", "rspValid in reset", rspValid, 0);
    check(coalesced === 1'b0 && txnCount === '0, "R10", "coalesced/count in reset",
          {coalesced, txnCount}, 0);
    check(txnBase === '0 && txnLen === '0, "R10", "base/len in reset", txnBase, 0);
    reqValid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      reqValid = 1'b0;
      checkResult(VECS[k], $sformatf("R%0d vec%0d", VECS[k].tag, k));
    end

    // R1: no response without a request
    @(negedge clk);
    check(rspValid === 1'b0, "R1", "idle rspValid", rspValid, 0);

    // R9: all-inactive warp
    e = '{16'h0000, 2'd0, 32'h0000_1000, K_NONE, 4'd0, 4'd0, 1'b0, 4'd9};
    drive(e);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, "R9", "empty rspValid", rspValid, 1);
    check(coalesced === 1'b0 && txnCount === '0, "R9", "empty coalesced/count",
          {coalesced, txnCount}, 0);
    check(txnBase === '0 && txnLen === '0, "R9", "empty base/len", txnLen, 0);

    // R1: back-to-back requests
    drive(VECS[7]);
    @(negedge clk);
    checkResult(VECS[7], "R1 b2b first");
    drive(VECS[2]);
    @(negedge clk);
    reqValid = 1'b0;
    checkResult(VECS[2], "R1 b2b second");

    // R10: reset after a merged result clears everything
    rst_n = 1'b0;
    #1;
    check(rspValid === 1'b0 && coalesced === 1'b0, "R10", "mid-run reset flags",
          {rspValid, coalesced}, 0);
    check(txnBase === '0 && txnLen === '0 && txnCount === '0, "R10",
          "mid-run reset fields", txnLen, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule